// File: doc/BRIEF.md
# Double-Buffered DAC Code Register Bank

This block keeps the digital codes for a bank of four 8-bit DAC channels. Each channel has two registers. A pending register takes writes from a simple single-cycle register bus. An active register drives the code that the converter sees. Values move from pending to active only when a load occurs. That split lets software stage new codes on every channel and then switch all outputs at the same moment.

A load can come from any of three sources:
- an active-low external load pin, after synchronization, when a qualified falling edge is seen;
- automatically on every channel write, if the configuration register selects that mode;
- a write to a load register, where a per-channel mask chooses which channels to update.

A configuration register also holds a global power-down flag. The converters use this flag to turn off and float their outputs. The serial front end and the analog circuitry sit outside this block.

Top module: `dac_dbuf_bank`

## Requirements
- R1: After reset, all active codes read as zero, `pwr_down` is low, and the configuration register at 0x1B reads as zero, which selects the pin load mode.
- R2: A write to channel address 0x10+i (i = 0..3) changes only pending register i. No active code and no `dac_code` field changes unless a load occurs.
- R3: A read of channel address 0x10+i returns active code i, which is the value on `dac_code[8*i+7:8*i]`. A newly written pending value becomes readable only after a load.
- R4: In pin mode, a load requires `load_n` to be sampled low on two consecutive rising clock edges after it was high. The first of these two edges is called edge k. At edge k+3, all four active registers take their pending values.
- R5: If `load_n` is low for a single clock sample, no load happens.
- R6: After a pin-triggered load, holding `load_n` low causes no further load. `load_n` must be sampled high and then fall again (per R4) before the pin can load again.
- R7: Bits 5:4 of the configuration register at 0x1B select the load mode: 00 means pin, 01 means load on every channel write, 10 means load-register only, and 11 behaves like 00. In modes 01 and 10, the pin has no effect.
- R8: In every mode, writing 0x1C with mask bits 3:0 loads each channel i whose mask bit i is set, at the same clock edge as the write. Channels whose mask bit is clear keep their active code. Address 0x1C always reads as zero.
- R9: If a load and a write to the same channel happen at the same edge, the active register takes the newly written value.
- R10: Bit 0 of the configuration register drives `pwr_down` from the next edge onward. Power-down leaves every stored code and every load path working.
- R11: Every channel carries all 256 straight-binary codes unchanged, from 0x00 to 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, one write per cycle |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Combinational readback of the addressed register |
| load_n | input | 1 | Asynchronous active-low external load request |
| dac_code | output | 32 | Active codes, channel i in bits 8*i+7:8*i |
| pwr_down | output | 1 | Power-down flag: converters off, outputs high impedance |

## Verification
The properties assume the following about the bus:
- at most one register access per cycle, with `wr_data` stable while `wr_en` is high;
- `rst` is held for several cycles so that the pin synchronizer starts filled with ones.

The stimulus drives every input on the falling clock edge, so writes never overlap. It holds `load_n` for a whole number of clock periods. The one case of a write coinciding with a load is built by counting synchronizer stages, so the write lands exactly on the pin load edge.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;

    localparam int NCH_DEF = 4;
    localparam int CODE_W_DEF = 8;
    localparam int ADDR_W_DEF = 8;

    // configuration register field positions
    localparam int CFG_MODE_LSB = 4;
    localparam int CFG_PD_BIT   = 0;

    typedef enum logic [1:0] {
        LDM_PIN     = 2'b00,
        LDM_AUTO    = 2'b01,
        LDM_REG     = 2'b10,
        LDM_PIN_ALT = 2'b11
    } ldmode_e;

    typedef struct packed {
        ldmode_e mode;
        logic    pd;
    } cfg_t;

    localparam cfg_t CFG_RESET = '{mode: LDM_PIN, pd: 1'b0};

    function automatic logic pin_loads(input ldmode_e m);
        return (m == LDM_PIN) || (m == LDM_PIN_ALT);
    endfunction

endpackage

// File: rtl/dac_ldpin_detect.sv
module dac_ldpin_detect #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_LOW     = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n,
    output logic fire
);
    localparam int LEN = SYNC_STAGES + MIN_LOW - 1;

    logic [LEN-1:0] chain_q;
    logic           armed_q;
    logic           win_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '1;
        end else begin
            chain_q <= {chain_q[LEN-2:0], pin_n};
        end
    end

    // all samples in the qualification window are low
    assign win_low = (chain_q[LEN-1:SYNC_STAGES-1] == '0);
    assign fire    = armed_q && win_low;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b1;
        end else if (chain_q[SYNC_STAGES-1]) begin
            armed_q <= 1'b1;
        end else if (fire) begin
            armed_q <= 1'b0;
        end
    end

endmodule

// File: rtl/dac_chan_reg.sv
module dac_chan_reg #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [CODE_W-1:0] wr_data,
    input  logic              load,
    output logic [CODE_W-1:0] active
);
    logic [CODE_W-1:0] pend_q;
    logic [CODE_W-1:0] pend_nx;

    // a write in the load cycle passes straight through
    assign pend_nx = wr_hit ? wr_data : pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            active <= '0;
        end else begin
            pend_q <= pend_nx;
            if (load) begin
                active <= pend_nx;
            end
        end
    end

endmodule

// File: rtl/dac_reg_decode.sv
module dac_reg_decode
    import dac_dbuf_pkg::*;
#(
    parameter int               NCH      = 4,
    parameter int               CODE_W   = 8,
    parameter int               ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CH_BASE  = 8'h10,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h1B,
    parameter logic [ADDR_W-1:0] LD_ADDR  = 8'h1C
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [CODE_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic [NCH*CODE_W-1:0] act_flat,
    input  logic                  pin_fire,
    output logic [NCH-1:0]        ch_wr,
    output logic [NCH-1:0]        ch_load,
    output logic                  ld_any,
    output cfg_t                  cfg,
    output logic [CODE_W-1:0]     rd_data
);
    logic lreg_wr;
    logic cfg_wr;
    logic pin_ld;

    assign lreg_wr = wr_en && (wr_addr == LD_ADDR);
    assign cfg_wr  = wr_en && (wr_addr == CFG_ADDR);
    assign pin_ld  = pin_fire && pin_loads(cfg.mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (cfg_wr) begin
            cfg.mode <= ldmode_e'(wr_data[CFG_MODE_LSB +: 2]);
            cfg.pd   <= wr_data[CFG_PD_BIT];
        end
    end

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            ch_wr[i]   = wr_en && (wr_addr == CH_BASE + ADDR_W'(i));
            ch_load[i] = (lreg_wr && wr_data[i])
                       || pin_ld
                       || ((cfg.mode == LDM_AUTO) && ch_wr[i]);
        end
    end

    assign ld_any = |ch_load;

    always_comb begin
        rd_data = '0;
        if (rd_addr == CFG_ADDR) begin
            rd_data[CFG_MODE_LSB +: 2] = cfg.mode;
            rd_data[CFG_PD_BIT]        = cfg.pd;
        end
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr == CH_BASE + ADDR_W'(i)) begin
                rd_data = act_flat[i*CODE_W +: CODE_W];
            end
        end
    end

endmodule

// File: rtl/dac_dbuf_bank.sv
module dac_dbuf_bank
    import dac_dbuf_pkg::*;
#(
    parameter int               NCH      = NCH_DEF,
    parameter int               CODE_W   = CODE_W_DEF,
    parameter int               ADDR_W   = ADDR_W_DEF,
    parameter logic [ADDR_W-1:0] CH_BASE  = 8'h10,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h1B,
    parameter logic [ADDR_W-1:0] LD_ADDR  = 8'h1C,
    parameter int               SYNC_STAGES = 2,
    parameter int               MIN_LOW     = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [CODE_W-1:0]     wr_data,
    input  logic [ADDR_W-1:0]     rd_addr,
    output logic [CODE_W-1:0]     rd_data,
    input  logic                  load_n,
    output logic [NCH*CODE_W-1:0] dac_code,
    output logic                  pwr_down
);
    logic           pin_fire;
    logic [NCH-1:0] ch_wr;
    logic [NCH-1:0] ch_load;
    logic           ld_any;
    cfg_t           cfg;

    dac_ldpin_detect #(
        .SYNC_STAGES(SYNC_STAGES),
        .MIN_LOW    (MIN_LOW)
    ) u_pin (
        .clk  (clk),
        .rst  (rst),
        .pin_n(load_n),
        .fire (pin_fire)
    );

    dac_reg_decode #(
        .NCH     (NCH),
        .CODE_W  (CODE_W),
        .ADDR_W  (ADDR_W),
        .CH_BASE (CH_BASE),
        .CFG_ADDR(CFG_ADDR),
        .LD_ADDR (LD_ADDR)
    ) u_dec (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .act_flat(dac_code),
        .pin_fire(pin_fire),
        .ch_wr   (ch_wr),
        .ch_load (ch_load),
        .ld_any  (ld_any),
        .cfg     (cfg),
        .rd_data (rd_data)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dac_chan_reg #(
            .CODE_W(CODE_W)
        ) u_ch (
            .clk    (clk),
            .rst    (rst),
            .wr_hit (ch_wr[g]),
            .wr_data(wr_data),
            .load   (ch_load[g]),
            .active (dac_code[g*CODE_W +: CODE_W])
        );
    end

    assign pwr_down = cfg.pd;

endmodule

// File: rtl/dac_dbuf_bank_chk.sv
module dac_dbuf_bank_chk
    import dac_dbuf_pkg::*;
#(
    parameter int               NCH      = 4,
    parameter int               CODE_W   = 8,
    parameter int               ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CH_BASE  = 8'h10,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h1B,
    parameter logic [ADDR_W-1:0] LD_ADDR  = 8'h1C
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  wr_en,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic [CODE_W-1:0]     wr_data,
    input logic [ADDR_W-1:0]     rd_addr,
    input logic [CODE_W-1:0]     rd_data,
    input logic [NCH*CODE_W-1:0] dac_code,
    input logic                  pwr_down,
    input logic                  ld_any,
    input logic                  pin_fire,
    input cfg_t                  cfg
);
    // R2: without any load request the active codes hold
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !ld_any |=> $stable(dac_code));

    // R3: channel readback mirrors the active code
    for (genvar g = 0; g < NCH; g++) begin : g_rb
        assert_readback_R3: assert property (@(posedge clk) disable iff (rst)
            (rd_addr == CH_BASE + ADDR_W'(g)) |-> (rd_data == dac_code[g*CODE_W +: CODE_W]));
    end

    // R6: a pin load cannot repeat on the next cycle
    assert_pin_rearm_R6: assert property (@(posedge clk) disable iff (rst)
        pin_fire |=> !pin_fire);

    // R7: in auto mode a channel 0 write reaches the output at the next edge
    assert_auto_load_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cfg.mode == LDM_AUTO && wr_addr == CH_BASE)
        |=> (dac_code[CODE_W-1:0] == $past(wr_data)));

    // R8: load register always reads zero
    assert_ldreg_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == LD_ADDR) |-> (rd_data == '0));

    // R10: power-down follows bit 0 of a configuration write
    assert_pd_follow_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == CFG_ADDR) |=> (pwr_down == $past(wr_data[CFG_PD_BIT])));

endmodule

bind dac_dbuf_bank dac_dbuf_bank_chk #(
    .NCH     (NCH),
    .CODE_W  (CODE_W),
    .ADDR_W  (ADDR_W),
    .CH_BASE (CH_BASE),
    .CFG_ADDR(CFG_ADDR),
    .LD_ADDR (LD_ADDR)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .dac_code(dac_code),
    .pwr_down(pwr_down),
    .ld_any  (ld_any),
    .pin_fire(pin_fire),
    .cfg     (cfg)
);

// File: tb/dac_dbuf_bank_test.sv
module dac_dbuf_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int W = 8;
    localparam logic [7:0] CH0 = 8'h10;
    localparam logic [7:0] CFG = 8'h1B;
    localparam logic [7:0] LDR = 8'h1C;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic load_n = 1'b1;
    logic [NCH*W-1:0] dac_code;
    logic pwr_down;

    int nchk = 0;
    int nerr = 0;
    logic [7:0] exp_act [NCH];
    logic [7:0] exp_pend[NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    dac_dbuf_bank uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .load_n(load_n), .dac_code(dac_code), .pwr_down(pwr_down)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_ch(input int ch, input logic [7:0] d, input bit auto_ld);
        wr(CH0 + 8'(ch), d);
        exp_pend[ch] = d;
        if (auto_ld) exp_act[ch] = d;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic check_all(input string tag);
        logic [7:0] v;
        for (int c = 0; c < NCH; c++) begin
            chk(tag, 32'(dac_code[c*W +: W]), 32'(exp_act[c]));
            rd(CH0 + 8'(c), v);
            chk(tag, 32'(v), 32'(exp_act[c]));
        end
    endtask

    task automatic pin_low(input int ncyc);
        load_n = 1'b0;
        repeat (ncyc) @(negedge clk);
        load_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic load_all_model();
        for (int c = 0; c < NCH; c++) exp_act[c] = exp_pend[c];
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [7:0] v;
        for (int c = 0; c < NCH; c++) begin exp_act[c] = '0; exp_pend[c] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check_all("R1 code");
        chk("R1 pwr_down", 32'(pwr_down), 0);
        rd(CFG, v); chk("R1 cfg", 32'(v), 0);

        // R2 / R3 writes stay pending
        for (int c = 0; c < NCH; c++) wr_ch(c, 8'(8'h21 * (c + 1)), 0);
        repeat (2) @(negedge clk);
        check_all("R2 R3 pending hidden");

        // R4 qualified pin pulse loads all
        pin_low(2);
        load_all_model();
        check_all("R4 pin load");

        // R5 one-cycle pulse ignored
        for (int c = 0; c < NCH; c++) wr_ch(c, 8'(8'h5A + c), 0);
        pin_low(1);
        check_all("R5 short pulse");
        pin_low(3);
        load_all_model();
        check_all("R5 longer pulse loads");

        // R6 held low does not reload
        load_n = 1'b0;
        repeat (5) @(negedge clk);
        for (int c = 0; c < NCH; c++) wr_ch(c, 8'(8'hC0 + c), 0);
        repeat (5) @(negedge clk);
        check_all("R6 held low");
        load_n = 1'b1;
        repeat (4) @(negedge clk);
        check_all("R6 rising no load");
        pin_low(2);
        load_all_model();
        check_all("R6 re-armed load");

        // R9 write coinciding with the pin load edge
        for (int c = 0; c < NCH; c++) wr_ch(c, 8'(8'h30 + c), 0);
        load_n = 1'b0;
        repeat (3) @(negedge clk);
        wr_ch(2, 8'hE7, 0);
        load_n = 1'b1;
        repeat (4) @(negedge clk);
        load_all_model();
        check_all("R9 coincident write");

        // R7 auto mode and R11 full code sweep
        wr(CFG, 8'h10);
        rd(CFG, v); chk("R7 cfg auto", 32'(v), 32'h10);
        for (int k = 0; k < 256; k++) begin
            for (int c = 0; c < NCH; c++) begin
                wr_ch(c, 8'((k * 37 + c * 11) & 255), 1);
                chk("R11 R7 auto code", 32'(dac_code[c*W +: W]), 32'(exp_act[c]));
            end
        end
        check_all("R7 auto final");

        // R7 register-only mode: pin ignored
        wr(CFG, 8'h20);
        for (int c = 0; c < NCH; c++) wr_ch(c, 8'(8'h90 + c), 0);
        pin_low(3);
        check_all("R7 reg mode pin ignored");

        // R8 mask sweep
        for (int m = 0; m < 16; m++) begin
            for (int c = 0; c < NCH; c++) wr_ch(c, 8'(m * 16 + c * 3 + 1), 0);
            wr(LDR, 8'(m));
            for (int c = 0; c < NCH; c++) if (m[c]) exp_act[c] = exp_pend[c];
            check_all("R8 mask load");
            rd(LDR, v); chk("R8 ldreg reads zero", 32'(v), 0);
        end

        // R7 mode 11 acts as pin
        wr(CFG, 8'h30);
        for (int c = 0; c < NCH; c++) wr_ch(c, 8'(8'h71 + c), 0);
        check_all("R7 mode11 before");
        pin_low(2);
        load_all_model();
        check_all("R7 mode11 pin load");

        // R10 power-down
        wr(CFG, 8'h01);
        chk("R10 pd on", 32'(pwr_down), 1);
        rd(CFG, v); chk("R10 cfg", 32'(v), 32'h01);
        check_all("R10 codes kept");
        for (int c = 0; c < NCH; c++) wr_ch(c, 8'(8'hF0 + c), 0);
        pin_low(2);
        load_all_model();
        check_all("R10 load while down");
        wr(CFG, 8'h00);
        chk("R10 pd off", 32'(pwr_down), 0);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule